// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting supervision timer with a restart window. Software has to restart it before the count runs out, but a restart that comes too early also counts as a fault. The count drops by one on each pulse of a slow tick-enable input. It reloads from a programmed reload value when software restarts it inside the window, or when it runs past zero.

The settings come from a single mode word. After reset, only the first write of that word takes effect. The word holds the reload value, the window limit, how faults are routed, a disable bit and two freeze bits. A fault is either an underflow or a restart made above the window limit. A fault can raise an interrupt line. It can also pulse a processor-only reset, or pulse both the processor reset and the system reset. Two sticky status flags record which kind of fault happened, and a read strobe clears them. Two status inputs, one for debug state and one for idle, can freeze the count.

Top module: `wdt_window_top`

## Requirements
- R1: Out of reset, the count is 0xFFF, both status flags are 0, and the interrupt and both reset outputs are low. In this state the window limit is 0xFFF, reset routing is enabled with all resets selected, and the interrupt is disabled.
- R2: Only the first mode write after reset is accepted, and writing it loads the count with the new reload value on the same edge. Later writes are ignored. The mode word layout is: reload value in bits 11:0, interrupt enable in bit 12, reset enable in bit 13, processor-only select in bit 14, disable in bit 15, window limit in bits 27:16, debug freeze in bit 28, idle freeze in bit 29.
- R3: Each tick-enable pulse lowers a nonzero count by one. A cycle with no tick leaves the count unchanged.
- R4: A tick while the count is 0 reloads the reload value and sets the sticky underflow flag.
- R5: A restart while the count is less than or equal to the window limit reloads the reload value and raises no fault.
- R6: A restart while the count is above the window limit leaves the count unchanged and sets the sticky window-error flag.
- R7: The interrupt output is high while either status flag is set and interrupt enable is 1. It stays low when interrupt enable is 0.
- R8: On a fault with reset enable at 1, the reset outputs pulse for exactly one cycle, starting on the edge that records the fault. With processor-only select at 1, only the processor reset pulses. With it at 0, both the processor reset and the system reset pulse. With reset enable at 0, neither reset output pulses.
- R9: With debug freeze set, ticks are ignored while the debug input is high. With idle freeze set, ticks are ignored while the idle input is high. A freeze bit that is clear has no effect.
- R10: With the disable bit set, ticks and restarts are ignored and no fault is raised.
- R11: A status read clears both flags on the next edge. A fault recorded on the same edge as a read leaves its flag set.
- R12: When a tick and a restart arrive in the same cycle, an in-window restart reloads the count and the tick is dropped. An out-of-window restart sets the error flag and the tick still lowers the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-down enable pulse |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | 32 | Mode word |
| restart_req | input | 1 | Software restart strobe |
| dbg_state | input | 1 | Processor is in debug state |
| idle_state | input | 1 | System is idle |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| count_val | output | 12 | Current count |
| stat_underflow | output | 1 | Sticky underflow flag |
| stat_winerr | output | 1 | Sticky window-error flag |
| irq | output | 1 | Fault interrupt |
| proc_rst | output | 1 | Processor reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
A restart and a tick can arrive on the same edge, and which one takes effect depends on whether the restart is accepted. The bench sweeps every window limit against every count for a small reload value and issues the restart alone. It then fires restarts together with ticks, one case inside the window and one outside. The expected count and error flag come from comparing the count with the limit: an accepted restart must reload and drop the tick, and a rejected one must flag and still let the tick lower the count. A fault recorded on the same edge as a status read is also provoked, and its flag must stay set.

// File: rtl/wdt_pkg.sv
// Shared types for the windowed watchdog: mode-word field positions,
// the decoded mode record, its reset value and the decode function.
// Assumes CNT_W <= 12 so the window field fits at its fixed offset.
package wdt_pkg;
    parameter int CNT_W  = 12;
    parameter int MODE_W = 32;

    localparam int IRQ_POS  = CNT_W;
    localparam int RST_POS  = CNT_W + 1;
    localparam int PROC_POS = CNT_W + 2;
    localparam int STOP_POS = CNT_W + 3;
    localparam int WIN_LSB  = 16;
    localparam int DBG_POS  = WIN_LSB + CNT_W;
    localparam int IDLE_POS = DBG_POS + 1;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] window;
        logic             irq_en;
        logic             rst_en;
        logic             proc_only;
        logic             stop;
        logic             dbg_frz;
        logic             idle_frz;
    } wdt_mode_t;

    localparam wdt_mode_t MODE_RST = '{
        reload:    {CNT_W{1'b1}},
        window:    {CNT_W{1'b1}},
        irq_en:    1'b0,
        rst_en:    1'b1,
        proc_only: 1'b0,
        stop:      1'b0,
        dbg_frz:   1'b0,
        idle_frz:  1'b0
    };

    // Split a raw mode word into its fields.
    function automatic wdt_mode_t decode_mode(input logic [MODE_W-1:0] w);
        wdt_mode_t m;
        m.reload    = w[CNT_W-1:0];
        m.window    = w[WIN_LSB +: CNT_W];
        m.irq_en    = w[IRQ_POS];
        m.rst_en    = w[RST_POS];
        m.proc_only = w[PROC_POS];
        m.stop      = w[STOP_POS];
        m.dbg_frz   = w[DBG_POS];
        m.idle_frz  = w[IDLE_POS];
        return m;
    endfunction
endpackage

// File: rtl/wdt_mode_reg.sv
// Write-once mode register. The first write after reset is decoded
// and held, and the register then locks until the next reset.
// 'accept' is high in the cycle a write takes effect.
module wdt_mode_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output wdt_mode_t         mode,
    output logic              accept
);
    logic      locked;
    wdt_mode_t decoded;

    // A write counts only while the register is still open.
    assign accept  = wr_en & ~locked;
    assign decoded = decode_mode(wr_data);

    // Capture the first write and lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            mode   <= MODE_RST;
        end else if (accept) begin
            locked <= 1'b1;
            mode   <= decoded;
        end
    end

    assert_locked_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en) |=> $stable(mode));
    assert_lock_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> locked);
endmodule

// File: rtl/wdt_counter.sv
// Down counter with restart-window check. Priority order: mode load,
// accepted restart, tick. A rejected restart flags an error, and a
// tick in the same cycle still counts. Emits single-cycle underflow
// and window-error events.
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wdt_mode_t        mode,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             restart,
    input  logic             dbg_in,
    input  logic             idle_in,
    output logic [CNT_W-1:0] count,
    output logic             uf_evt,
    output logic             err_evt
);
    logic frozen;
    logic in_window;
    logic restart_ok;
    logic step;

    // Freeze when an enabled halt condition is present.
    assign frozen     = (mode.dbg_frz & dbg_in) | (mode.idle_frz & idle_in);
    // The window check uses the count before this cycle's tick.
    assign in_window  = (count <= mode.window);
    assign restart_ok = restart & ~mode.stop & ~load_now & in_window;
    assign err_evt    = restart & ~mode.stop & ~load_now & ~in_window;
    // A tick counts only when no higher-priority reload happens.
    assign step       = tick & ~mode.stop & ~frozen & ~load_now & ~restart_ok;
    assign uf_evt     = step & (count == '0);

    // Count register update by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= {CNT_W{1'b1}};
        else if (load_now)
            count <= load_val;
        else if (restart_ok)
            count <= mode.reload;
        else if (step)
            count <= (count == '0) ? mode.reload : count - 1'b1;
    end

    assert_underflow_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (count == $past(mode.reload)));
    assert_inwindow_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !mode.stop && !load_now && count <= mode.window) |=> (count == $past(mode.reload)));
    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && !tick) |=> $stable(count));
    assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !restart && !load_now) |=> $stable(count));
    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.stop && !load_now) |=> $stable(count));
    assert_stop_nofault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode.stop |-> !(uf_evt || err_evt));
endmodule

// File: rtl/wdt_fault_route.sv
// Fault routing: sticky status flags cleared by a read (a new fault
// wins over the clear), an interrupt level gated by interrupt enable,
// and one-cycle reset pulses selected by the routing bits.
module wdt_fault_route
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wdt_mode_t mode,
    input  logic      uf_evt,
    input  logic      err_evt,
    input  logic      stat_rd,
    output logic      flag_uf,
    output logic      flag_err,
    output logic      irq,
    output logic      proc_rst,
    output logic      sys_rst
);
    logic fault;

    assign fault = uf_evt | err_evt;

    // Sticky flags: set on an event, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_uf  <= 1'b0;
            flag_err <= 1'b0;
        end else begin
            flag_uf  <= uf_evt  | (flag_uf  & ~stat_rd);
            flag_err <= err_evt | (flag_err & ~stat_rd);
        end
    end

    // Reset pulses, one cycle per fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_rst <= 1'b0;
            sys_rst  <= 1'b0;
        end else begin
            proc_rst <= fault & mode.rst_en;
            sys_rst  <= fault & mode.rst_en & ~mode.proc_only;
        end
    end

    // Interrupt follows the flags when enabled.
    assign irq = mode.irq_en & (flag_uf | flag_err);

    assert_irq_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && mode.irq_en) |=> irq);
    assert_sys_implies_proc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> proc_rst);
    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proc_rst |-> $past(fault));
    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fault) |=> (!flag_uf && !flag_err));
endmodule

// File: rtl/wdt_window_top.sv
// Top of the windowed watchdog. Joins the write-once mode register,
// the windowed down counter and the fault router. Assumes the tick,
// restart and read strobes are single-cycle pulses in the clk domain.
module wdt_window_top
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              restart_req,
    input  logic              dbg_state,
    input  logic              idle_state,
    input  logic              stat_rd,
    output logic [CNT_W-1:0]  count_val,
    output logic              stat_underflow,
    output logic              stat_winerr,
    output logic              irq,
    output logic              proc_rst,
    output logic              sys_rst
);
    wdt_mode_t mode;
    logic      accept;
    logic      uf_evt;
    logic      err_evt;

    wdt_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_data (mode_wdata),
        .mode    (mode),
        .accept  (accept)
    );

    wdt_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .load_now (accept),
        .load_val (mode_wdata[CNT_W-1:0]),
        .tick     (tick_en),
        .restart  (restart_req),
        .dbg_in   (dbg_state),
        .idle_in  (idle_state),
        .count    (count_val),
        .uf_evt   (uf_evt),
        .err_evt  (err_evt)
    );

    wdt_fault_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .uf_evt   (uf_evt),
        .err_evt  (err_evt),
        .stat_rd  (stat_rd),
        .flag_uf  (stat_underflow),
        .flag_err (stat_winerr),
        .irq      (irq),
        .proc_rst (proc_rst),
        .sys_rst  (sys_rst)
    );

    assert_single_fault_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(uf_evt && err_evt));
endmodule

// File: tb/wdt_window_top_tb.sv
`timescale 1ns/1ps
module wdt_window_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        mode_wr = 1'b0;
    logic [31:0] mode_wdata = '0;
    logic        restart_req = 1'b0;
    logic        dbg_state = 1'b0;
    logic        idle_state = 1'b0;
    logic        stat_rd = 1'b0;
    logic [11:0] count_val;
    logic        stat_underflow, stat_winerr, irq, proc_rst, sys_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdt_window_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .restart_req(restart_req),
        .dbg_state(dbg_state), .idle_state(idle_state), .stat_rd(stat_rd),
        .count_val(count_val), .stat_underflow(stat_underflow),
        .stat_winerr(stat_winerr), .irq(irq), .proc_rst(proc_rst), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int wdv, input bit ie, input bit re,
                                       input bit po, input bit dis, input int wdd,
                                       input bit dh, input bit ih);
        logic [31:0] w;
        w = '0;
        w[11:0]  = wdv[11:0];
        w[12]    = ie;
        w[13]    = re;
        w[14]    = po;
        w[15]    = dis;
        w[27:16] = wdd[11:0];
        w[28]    = dh;
        w[29]    = ih;
        return w;
    endfunction

    // One clock with the given strobes; returns at the following negedge.
    task automatic cyc(input bit t, input bit r, input bit s);
        tick_en = t; restart_req = r; stat_rd = s;
        @(posedge clk); @(negedge clk);
        tick_en = 0; restart_req = 0; stat_rd = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; mode_wr = 0; dbg_state = 0; idle_state = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr_mode(input logic [31:0] d);
        mode_wr = 1; mode_wdata = d;
        @(posedge clk); @(negedge clk);
        mode_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 count", count_val, 12'hFFF);
        chk("R1 flags", {stat_underflow, stat_winerr}, 0);
        chk("R1 outs", {irq, proc_rst, sys_rst}, 0);
        cyc(1, 0, 0);
        chk("R3 first tick", count_val, 12'hFFE);
        cyc(0, 1, 0);
        chk("R1 default window accepts restart", count_val, 12'hFFF);
        chk("R1 no error", stat_winerr, 0);

        // R2 write once
        do_reset();
        wr_mode(mk(5, 0, 1, 1, 0, 12'hFFF, 0, 0));
        chk("R2 load on write", count_val, 5);
        wr_mode(mk(9, 0, 1, 1, 0, 12'hFFF, 0, 0));
        chk("R2 second write ignored", count_val, 5);
        for (int i = 0; i < 6; i++) cyc(1, 0, 0);
        chk("R2 reload keeps first value", count_val, 5);

        // R3 R4 R7 R8 R11 underflow sweep over reload values and routing
        for (int w = 0; w <= 4; w++) begin
            for (int ie = 0; ie <= 1; ie++) begin
                for (int rc = 0; rc < 3; rc++) begin
                    bit re, po;
                    re = (rc != 0);
                    po = (rc == 2);
                    do_reset();
                    wr_mode(mk(w, ie[0], re, po, 0, 12'hFFF, 0, 0));
                    for (int k = 1; k <= w; k++) begin
                        cyc(1, 0, 0);
                        chk("R3 decrement", count_val, w - k);
                    end
                    cyc(0, 0, 0);
                    chk("R3 hold without tick", count_val, 0);
                    chk("R8 no pulse before fault", {proc_rst, sys_rst}, 0);
                    cyc(1, 0, 0);
                    chk("R4 reload", count_val, w);
                    chk("R4 underflow flag", stat_underflow, 1);
                    chk("R7 irq", irq, ie);
                    chk("R8 proc_rst", proc_rst, re);
                    chk("R8 sys_rst", sys_rst, re & ~po);
                    cyc(0, 0, 0);
                    chk("R8 pulse ends", {proc_rst, sys_rst}, 0);
                    chk("R4 flag sticky", stat_underflow, 1);
                    cyc(0, 0, 1);
                    chk("R11 read clears", stat_underflow, 0);
                    chk("R7 irq drops", irq, 0);
                end
            end
        end

        // R5 R6 window sweep: reload 6, every limit 0..7, every count
        for (int d = 0; d <= 7; d++) begin
            for (int k = 0; k <= 6; k++) begin
                bit ok;
                do_reset();
                wr_mode(mk(6, 1, 1, 1, 0, d, 0, 0));
                for (int i = 0; i < k; i++) cyc(1, 0, 0);
                ok = ((6 - k) <= d);
                cyc(0, 1, 0);
                chk(ok ? "R5 count" : "R6 count", count_val, ok ? 6 : 6 - k);
                chk(ok ? "R5 no error" : "R6 error flag", stat_winerr, !ok);
                chk(ok ? "R5 no pulse" : "R8 error pulse", proc_rst, !ok);
                chk("R7 irq on error", irq, !ok);
            end
        end

        // R9 freeze
        do_reset();
        wr_mode(mk(8, 0, 1, 0, 0, 12'hFFF, 1, 0));
        dbg_state = 1;
        cyc(1, 0, 0);
        chk("R9 debug freeze", count_val, 8);
        dbg_state = 0; idle_state = 1;
        cyc(1, 0, 0);
        chk("R9 idle ignored when bit clear", count_val, 7);
        idle_state = 0;
        do_reset();
        wr_mode(mk(8, 0, 1, 0, 0, 12'hFFF, 0, 1));
        idle_state = 1;
        cyc(1, 0, 0);
        chk("R9 idle freeze", count_val, 8);
        idle_state = 0; dbg_state = 1;
        cyc(1, 0, 0);
        chk("R9 debug ignored when bit clear", count_val, 7);
        dbg_state = 0;

        // R10 disable
        do_reset();
        wr_mode(mk(3, 1, 1, 0, 1, 0, 0, 0));
        for (int i = 0; i < 6; i++) cyc(1, 0, 0);
        chk("R10 no count", count_val, 3);
        chk("R10 no underflow", stat_underflow, 0);
        cyc(0, 1, 0);
        chk("R10 restart ignored", {stat_winerr, irq, proc_rst, sys_rst}, 0);

        // R11 fault on read edge keeps flag
        do_reset();
        wr_mode(mk(0, 0, 0, 0, 0, 12'hFFF, 0, 0));
        cyc(1, 0, 0);
        cyc(1, 0, 1);
        chk("R11 set wins over clear", stat_underflow, 1);
        chk("R8 reset disabled", {proc_rst, sys_rst}, 0);
        cyc(0, 0, 1);
        chk("R11 later read clears", stat_underflow, 0);

        // R12 restart and tick together
        do_reset();
        wr_mode(mk(4, 0, 1, 0, 0, 2, 0, 0));
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk("R12 setup", count_val, 2);
        cyc(1, 1, 0);
        chk("R12 in-window restart beats tick", count_val, 4);
        chk("R12 no error", stat_winerr, 0);
        cyc(1, 1, 0);
        chk("R12 rejected restart still ticks", count_val, 3);
        chk("R12 error flag", stat_winerr, 1);
        chk("R12 both resets", {proc_rst, sys_rst}, 3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule